// File: doc/BRIEF.md
# Host Interface Access Error Checker

This block sits between an external parallel host port and an internal shared memory. It checks every host read and write in the cycle it arrives. It also assembles byte-wise host writes into complete 16-bit words before they go to memory. The block decides whether the host's write reaches memory, and it drives the memory write strobe, address and byte lanes for the host side. Device-side writes reach memory on their own path; the checker only watches them for collisions.

Four error classes are detected:

- a mismatch between the host data width and the requested access size;
- a write outside the legal write window;
- a read that lands on a word still waiting for its second byte;
- a host write that collides with a device write to the same address.

A protection, reserved-region or parity fault reported by the region lookup is a fifth condition, the access violation.

Each class has a sticky flag that software clears by writing 1 to it. The first error after the relevant flags were clean records its address: ordinary errors go to one capture register and access violations to another. Any flag that is also enabled in the mask drives a level interrupt.

Top module: `host_access_err_chk`

## Requirements
- R1: The host data width is 32 bits when `mode_dw32` is 1 or `host_be` is 4'b1111, and 16 bits otherwise. `acc_size` codes 0, 1 and 2 mean 8, 16 and 32 bits. A host write whose host width is larger than the access size sets flag bit 0 one cycle later and does not assert `host_mem_we`.
- R2: A host write to an address equal to or above `WR_LIMIT` (default 48) sets flag bit 0 and does not assert `host_mem_we`.
- R3: A host read whose host width is larger than the access size (same rule as R1) sets flag bit 1.
- R4: A host read to the address of a pending half-written word sets flag bit 1. It also discards the pending byte, so a later write of the other byte does not commit.
- R5: When a host write would commit in the same cycle as `dev_wr` with `dev_addr` equal to `host_addr`, flag bit 2 is set and `host_mem_we` stays 0.
- R6: A host access with `region_fault` high, or a host read with `parity_fault` high, sets flag bit 3 and does not assert `host_mem_we`.
- R7: In 16-bit mode a write with `host_be[1:0]`=2'b11 commits in the same cycle with `host_mem_be`=4'b0011. A single-byte write is held as pending. A second single-byte write to the same address that completes the pair commits with 4'b0011. In 32-bit mode a legal write commits with 4'b1111.
- R8: `err_addr` captures the host address of an error in flag bits 0 to 2 only while those bits are all clear. `viol_addr` captures the address of an access violation only while flag bit 3 is clear.
- R9: Flags are sticky. A 1 on a bit of `flag_clr` clears that bit at the next edge unless a new error of the same class arrives in the same cycle.
- R10: `irq` is 1 whenever any flag bit is set and the same bit of `irq_mask` is 1.
- R11: After reset, flags, `irq`, `err_addr` and `viol_addr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | AW (6) | Host word address |
| host_be | input | 4 | Host byte enables |
| mode_dw32 | input | 1 | Mode bit selecting 32-bit host width |
| acc_size | input | 2 | Requested access size: 0 = 8, 1 = 16, 2 = 32 bits |
| dev_wr | input | 1 | Device-side write strobe |
| dev_addr | input | AW (6) | Device-side write address |
| region_fault | input | 1 | Protected or reserved region hit |
| parity_fault | input | 1 | Parity/ECC fault on read data |
| flag_clr | input | 4 | Write-1-to-clear for the flag bits |
| irq_mask | input | 4 | Interrupt enable per flag bit |
| host_mem_we | output | 1 | Host write to memory granted |
| host_mem_addr | output | AW (6) | Address for the host memory write |
| host_mem_be | output | 4 | Byte lanes for the host memory write |
| flags | output | 4 | Sticky flags: 0 write, 1 read, 2 bus, 3 violation |
| err_addr | output | AW (6) | First captured ordinary error address |
| viol_addr | output | AW (6) | First captured violation address |
| irq | output | 1 | Level interrupt |

## Verification
A corrupt pending-byte register shows at the ports in one of two ways. A completing byte either fails to raise `host_mem_we` in its own cycle, or a read to that word sets flag bit 1 one edge later. A capture register that is overwritten shows up as a changed `err_addr` or `viol_addr` on the cycle after the second error. Width and range decisions are combinational, so a wrong decision shows on `host_mem_we` within the same cycle and on `flags` after one edge. The bench sweeps every mode, byte-enable and size combination for both reads and writes.

// File: rtl/hiec_pkg.sv
package hiec_pkg;
  localparam int NUM_ERR = 4;
  typedef enum int unsigned {
    ERR_WR   = 0,
    ERR_RD   = 1,
    ERR_BUS  = 2,
    ERR_VIOL = 3
  } err_idx_e;
  typedef enum logic [1:0] {
    SZ_8  = 2'd0,
    SZ_16 = 2'd1,
    SZ_32 = 2'd2
  } acc_sz_e;
endpackage

// File: rtl/hiec_width_chk.sv
module hiec_width_chk #(
  parameter int BEW = 4
) (
  input  logic           mode_dw32,
  input  logic [BEW-1:0] be,
  input  logic [1:0]     acc_size,
  output logic           hw32,
  output logic           mismatch
);
  import hiec_pkg::*;
  logic [1:0] host_code;

  always_comb begin
    hw32      = mode_dw32 | (&be);
    host_code = hw32 ? SZ_32 : SZ_16;
    mismatch  = (host_code > acc_size);
  end
endmodule

// File: rtl/hiec_partial.sv
module hiec_partial #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_go,
  input  logic          err_clr,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    be_lo,
  input  logic          hw32,
  output logic          pend_hit,
  output logic          commit,
  output logic [3:0]    commit_be
);
  logic          pv_q, pv_n;
  logic [AW-1:0] pa_q, pa_n;
  logic [1:0]    pb_q, pb_n;
  logic [1:0]    merged;
  logic          pend_en;

  assign pend_hit = pv_q && (pa_q == addr);
  assign pend_en  = wr_go | err_clr;

  always_comb begin
    pv_n      = pv_q;
    pa_n      = pa_q;
    pb_n      = pb_q;
    commit    = 1'b0;
    commit_be = 4'b0000;
    merged    = pend_hit ? (pb_q | be_lo) : be_lo;
    if (wr_go) begin
      if (hw32) begin
        commit    = 1'b1;
        commit_be = 4'b1111;
        if (pend_hit) pv_n = 1'b0;
      end else if (be_lo == 2'b11) begin
        commit    = 1'b1;
        commit_be = 4'b0011;
        if (pend_hit) pv_n = 1'b0;
      end else if (be_lo != 2'b00) begin
        if (merged == 2'b11) begin
          commit    = 1'b1;
          commit_be = 4'b0011;
          pv_n      = 1'b0;
        end else begin
          pv_n = 1'b1;
          pa_n = addr;
          pb_n = merged;
        end
      end
    end
    if (err_clr && pend_hit) pv_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q <= 1'b0;
      pa_q <= '0;
      pb_q <= 2'b00;
    end else if (pend_en) begin
      pv_q <= pv_n;
      pa_q <= pa_n;
      pb_q <= pb_n;
    end
  end

  AST_COMMIT_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (commit_be == 4'b0011 || commit_be == 4'b1111)); // R7
  AST_PEND_DROP_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && pend_hit && !wr_go) |=> !(pv_q && pa_q == $past(addr))); // R4
endmodule

// File: rtl/hiec_err_regs.sv
module hiec_err_regs #(
  parameter int AW = 6,
  parameter int NE = hiec_pkg::NUM_ERR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NE-1:0] new_err,
  input  logic [NE-1:0] flag_clr,
  input  logic [NE-1:0] irq_mask,
  input  logic [AW-1:0] haddr,
  output logic [NE-1:0] flags,
  output logic [AW-1:0] err_addr,
  output logic [AW-1:0] viol_addr,
  output logic          irq
);
  import hiec_pkg::*;
  logic [NE-1:0] kept, flags_n;
  logic          cap_err, cap_viol;

  always_comb begin
    kept     = flags & ~flag_clr;
    flags_n  = kept | new_err;
    cap_err  = (|new_err[ERR_BUS:ERR_WR]) && !(|kept[ERR_BUS:ERR_WR]);
    cap_viol = new_err[ERR_VIOL] && !kept[ERR_VIOL];
    irq      = |(flags & irq_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_addr <= '0;
    else if (cap_err) err_addr <= haddr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        viol_addr <= '0;
    else if (cap_viol) viol_addr <= haddr;
  end

  generate
    for (genvar i = 0; i < NE; i++) begin : g_sticky
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[i] && !flag_clr[i]) |=> flags[i]); // R9
    end
  endgenerate
  AST_ERRADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((|flags[ERR_BUS:ERR_WR]) && !(|flag_clr[ERR_BUS:ERR_WR])) |=> $stable(err_addr)); // R8
  AST_VIOLADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[ERR_VIOL] && !flag_clr[ERR_VIOL]) |=> $stable(viol_addr)); // R8
endmodule

// File: rtl/host_access_err_chk.sv
module host_access_err_chk #(
  parameter int AW       = 6,
  parameter int WR_LIMIT = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [AW-1:0] host_addr,
  input  logic [3:0]    host_be,
  input  logic          mode_dw32,
  input  logic [1:0]    acc_size,
  input  logic          dev_wr,
  input  logic [AW-1:0] dev_addr,
  input  logic          region_fault,
  input  logic          parity_fault,
  input  logic [3:0]    flag_clr,
  input  logic [3:0]    irq_mask,
  output logic          host_mem_we,
  output logic [AW-1:0] host_mem_addr,
  output logic [3:0]    host_mem_be,
  output logic [3:0]    flags,
  output logic [AW-1:0] err_addr,
  output logic [AW-1:0] viol_addr,
  output logic          irq
);
  import hiec_pkg::*;
  localparam int NE = NUM_ERR;
  localparam logic [AW:0] LIMIT = (AW+1)'(WR_LIMIT);

  logic          hw32, mismatch, pend_hit, commit;
  logic [3:0]    commit_be;
  logic          rd_act, range_bad, viol, e_wr, e_rd, e_bus, wr_go, err_clr;
  logic [NE-1:0] new_err;

  hiec_width_chk #(.BEW(4)) u_width (
    .mode_dw32 (mode_dw32),
    .be        (host_be),
    .acc_size  (acc_size),
    .hw32      (hw32),
    .mismatch  (mismatch)
  );

  always_comb begin
    rd_act    = host_rd & ~host_wr;
    range_bad = host_wr && ({1'b0, host_addr} >= LIMIT);
    viol      = ((host_wr | rd_act) & region_fault) | (rd_act & parity_fault);
    e_wr      = host_wr & (mismatch | range_bad);
    wr_go     = host_wr & ~mismatch & ~range_bad & ~viol;
    e_rd      = rd_act & (mismatch | pend_hit);
    err_clr   = e_wr | e_rd | viol;
  end

  hiec_partial #(.AW(AW)) u_partial (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_go     (wr_go),
    .err_clr   (err_clr),
    .addr      (host_addr),
    .be_lo     (host_be[1:0]),
    .hw32      (hw32),
    .pend_hit  (pend_hit),
    .commit    (commit),
    .commit_be (commit_be)
  );

  always_comb begin
    e_bus             = commit & dev_wr & (dev_addr == host_addr);
    host_mem_we       = commit & ~e_bus;
    host_mem_addr     = host_addr;
    host_mem_be       = commit_be;
    new_err           = '0;
    new_err[ERR_WR]   = e_wr;
    new_err[ERR_RD]   = e_rd;
    new_err[ERR_BUS]  = e_bus;
    new_err[ERR_VIOL] = viol;
  end

  hiec_err_regs #(.AW(AW), .NE(NE)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .new_err   (new_err),
    .flag_clr  (flag_clr),
    .irq_mask  (irq_mask),
    .haddr     (host_addr),
    .flags     (flags),
    .err_addr  (err_addr),
    .viol_addr (viol_addr),
    .irq       (irq)
  );

  AST_NO_WE_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    host_mem_we |-> !(mismatch || range_bad || region_fault)); // R1
  AST_BUS_HOST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_wr && host_wr && dev_addr == host_addr) |-> !host_mem_we); // R5
  AST_WE_SETS_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (host_mem_we && flag_clr == 4'hF) |=> flags == 4'h0); // R6
endmodule

// File: tb/tb_host_access_err_chk.sv
module tb_host_access_err_chk;
  localparam int AW = 6;
  localparam int LIM = 48;

  logic clk, rst_n;
  logic host_wr, host_rd, mode_dw32, dev_wr, region_fault, parity_fault;
  logic [AW-1:0] host_addr, dev_addr;
  logic [3:0] host_be, flag_clr, irq_mask;
  logic [1:0] acc_size;
  logic host_mem_we, irq;
  logic [AW-1:0] host_mem_addr, err_addr, viol_addr;
  logic [3:0] host_mem_be, flags;

  int n_chk, n_fail;

  host_access_err_chk #(.AW(AW), .WR_LIMIT(LIM)) dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_be(host_be), .mode_dw32(mode_dw32),
    .acc_size(acc_size), .dev_wr(dev_wr), .dev_addr(dev_addr),
    .region_fault(region_fault), .parity_fault(parity_fault),
    .flag_clr(flag_clr), .irq_mask(irq_mask), .host_mem_we(host_mem_we),
    .host_mem_addr(host_mem_addr), .host_mem_be(host_mem_be), .flags(flags),
    .err_addr(err_addr), .viol_addr(viol_addr), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    host_wr = 0; host_rd = 0; dev_wr = 0; region_fault = 0; parity_fault = 0;
    flag_clr = 4'h0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic acc(input logic wr, input logic [AW-1:0] a, input logic [3:0] be,
                     input logic m, input logic [1:0] sz);
    host_wr = wr; host_rd = ~wr; host_addr = a; host_be = be;
    mode_dw32 = m; acc_size = sz;
  endtask

  task automatic clear_all();
    idle(); flag_clr = 4'hF; step(); idle();
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    idle(); host_addr = '0; host_be = '0; mode_dw32 = 0; acc_size = 0;
    dev_addr = '0; irq_mask = 4'h0;
    rst_n = 0;
    #23 rst_n = 1;
    #1;
    chk("R11 flags", {28'd0, flags}, 0);
    chk("R11 irq", {31'd0, irq}, 0);
    chk("R11 err_addr", {26'd0, err_addr}, 0);
    chk("R11 viol_addr", {26'd0, viol_addr}, 0);

    // Sweep: every mode, byte enable and size for writes (R1, R7) and reads (R3)
    for (int k = 0; k < 96; k++) begin
      automatic logic m = k[0];
      automatic logic [3:0] be = k[4:1];
      automatic logic [1:0] sz = 2'(k / 32);
      automatic int hw = (m || be == 4'hF) ? 2 : 1;
      automatic logic bad = (hw > int'(sz));
      automatic logic we_e = !bad && (hw == 2 || be[1:0] == 2'b11);
      acc(1, AW'(k % LIM), be, m, sz); flag_clr = 4'hF; #1;
      chk("R1 write we", {31'd0, host_mem_we}, {31'd0, we_e});
      if (we_e) chk("R7 write lanes", {28'd0, host_mem_be}, (hw == 2) ? 4'hF : 4'h3);
      step();
      chk("R1 write flag", {28'd0, flags}, {31'd0, bad});
      acc(0, AW'(LIM + (k % 16)), be, m, sz); flag_clr = 4'hF; #1;
      chk("R3 read we", {31'd0, host_mem_we}, 0);
      step();
      chk("R3 read flag", {28'd0, flags}, {30'd0, bad, 1'b0});
    end
    clear_all();

    // R7 byte assembly
    acc(1, 10, 4'b0001, 0, 1); #1;
    chk("R7 first byte no we", {31'd0, host_mem_we}, 0);
    step();
    acc(1, 10, 4'b0010, 0, 1); #1;
    chk("R7 second byte we", {31'd0, host_mem_we}, 1);
    chk("R7 merged lanes", {28'd0, host_mem_be}, 4'h3);
    chk("R7 addr", {26'd0, host_mem_addr}, 10);
    step(); idle();
    chk("R7 no flag", {28'd0, flags}, 0);

    // R4 read of a pending word
    acc(1, 11, 4'b0001, 0, 1); step();
    acc(0, 11, 4'b0011, 0, 1); step();
    chk("R4 read-pending flag", {28'd0, flags}, 4'h2);
    acc(1, 11, 4'b0010, 0, 1); #1;
    chk("R4 pending dropped", {31'd0, host_mem_we}, 0);
    step(); idle();
    clear_all();

    // R5 collision
    acc(1, 12, 4'b0011, 0, 1); dev_wr = 1; dev_addr = 12; #1;
    chk("R5 host dropped", {31'd0, host_mem_we}, 0);
    step(); idle();
    chk("R5 bus flag", {28'd0, flags}, 4'h4);
    clear_all();
    acc(1, 12, 4'b0011, 0, 1); dev_wr = 1; dev_addr = 13; #1;
    chk("R5 other addr we", {31'd0, host_mem_we}, 1);
    step(); idle();
    chk("R5 no flag", {28'd0, flags}, 0);

    // R2 range
    acc(1, 50, 4'b0011, 0, 1); #1;
    chk("R2 no we", {31'd0, host_mem_we}, 0);
    step(); idle();
    chk("R2 flag", {28'd0, flags}, 4'h1);
    clear_all();

    // R6 and R8 violation capture
    acc(1, 30, 4'b0011, 0, 1); region_fault = 1; #1;
    chk("R6 no we", {31'd0, host_mem_we}, 0);
    step(); idle();
    chk("R6 region flag", {28'd0, flags}, 4'h8);
    chk("R8 viol_addr first", {26'd0, viol_addr}, 30);
    acc(0, 31, 4'b0011, 0, 1); parity_fault = 1; step(); idle();
    chk("R8 viol_addr held", {26'd0, viol_addr}, 30);
    clear_all();
    acc(0, 33, 4'b0011, 0, 1); parity_fault = 1; step(); idle();
    chk("R6 parity flag", {28'd0, flags}, 4'h8);
    chk("R8 viol_addr recapture", {26'd0, viol_addr}, 33);
    clear_all();

    // R8 error address capture
    acc(1, 20, 4'hF, 0, 1); step();
    acc(0, 21, 4'hF, 0, 0); step(); idle();
    chk("R8 err_addr first", {26'd0, err_addr}, 20);
    chk("R8 two flags", {28'd0, flags}, 4'h3);

    // R9 stickiness and per-bit clear
    step(); step();
    chk("R9 sticky", {28'd0, flags}, 4'h3);
    flag_clr = 4'h1; step(); idle();
    chk("R9 clear bit0", {28'd0, flags}, 4'h2);
    acc(0, 22, 4'hF, 0, 0); flag_clr = 4'h2; step(); idle();
    chk("R9 set beats clear", {28'd0, flags}, 4'h2);

    // R10 interrupt masking
    irq_mask = 4'h1; #1;
    chk("R10 masked", {31'd0, irq}, 0);
    irq_mask = 4'h2; #1;
    chk("R10 enabled", {31'd0, irq}, 1);
    clear_all(); #1;
    chk("R10 cleared", {31'd0, irq}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule